// File: doc/BRIEF.md
# Scoreboard Instruction Issue Controller

This block is the central hazard tracker for a datapath that executes instructions out of order with no result forwarding. Decoded instructions arrive in program order, one per cycle at most, each carrying a unit class, a destination register and two source registers. The controller decides when each instruction may enter a functional unit, when that unit may fetch its operands from the register file, and when the unit may put its result back. The units run the arithmetic themselves and report completion with a one-cycle pulse.

The controller keeps one status entry per functional unit (busy, destination, sources, producer tags, operand-ready flags, read and complete flags) and a table that maps each of the 16 registers (8 floating-point, 8 integer) to the unit that will write it. Five units are tracked: index 0 is integer, 1 and 2 are multipliers, 3 is the divider, 4 is the adder. Every grant is combinational from the stored state and the current inputs, and takes effect at the next rising edge.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset no unit is busy and rd_grant_o and wb_grant_o are zero; an instruction presented then is accepted in that same cycle.
- R2: Class codes are 0 integer, 1 multiply, 2 divide, 3 add; unit 0 serves class 0, units 1 and 2 class 1, unit 3 class 2, unit 4 class 3. An instruction is accepted only when a unit of its class is idle, and it is placed in the lowest-numbered idle unit of that class, reported on iss_fu_o.
- R3: An instruction is not accepted while any busy unit (including one being granted write-back in that cycle) has the same destination register.
- R4: While iss_accept_o is low the presented instruction is not taken and no unit changes to busy; instructions are accepted strictly in the order presented.
- R5: A unit's rd_grant_o bit rises only when no earlier-issued busy unit has as destination either of its source registers; at the earliest it rises in the cycle after that producer's write-back grant.
- R6: A unit whose sources have no pending producer gets rd_grant_o in the cycle after its issue, and each issued instruction gets exactly one read grant.
- R7: An ex_done_i pulse on a unit that has already been granted its operand read marks it complete; write-back may be granted from the next cycle on.
- R8: Write-back of a complete unit is withheld while an earlier-issued busy unit that has not yet read its operands has the unit's destination as a source.
- R9: At most one wb_grant_o bit is set per cycle; among eligible units the lowest index wins.
- R10: While a wb_grant_o bit is set, wb_reg_o gives the destination register of the granted unit.
- R11: A write-back grant frees the unit and its destination register: the next cycle a new instruction may be accepted into that unit or with that destination.
- R12: An ex_done_i pulse on an idle unit, or on a unit that has not yet been granted its read, is ignored and never leads to a write-back grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | A decoded instruction is presented |
| in_cls_i | input | 2 | Unit class of the instruction |
| in_dst_i | input | 4 | Destination register |
| in_src1_i | input | 4 | First source register |
| in_src2_i | input | 4 | Second source register |
| iss_accept_o | output | 1 | Instruction is taken at the next edge |
| iss_fu_o | output | 3 | Unit receiving the accepted instruction |
| rd_grant_o | output | 5 | Per unit: read operands from the register file now |
| ex_done_i | input | 5 | Per unit: execution finished pulse |
| wb_grant_o | output | 5 | Per unit: write result this cycle |
| wb_reg_o | output | 4 | Register written by the granted unit |

## Verification
The embedded assertions check on every cycle that at most one write-back is granted, that issue only targets an idle unit and leaves the destination mapped to it, that write-back only follows a completed read and execution, and that a unit is released after its write-back and reads its operands only once. The ordering hazards (a read waiting on an earlier producer, a write-back held by an earlier unread consumer, a stall on a pending destination, priority among simultaneous completions and pulses that must be ignored) need a history of several instructions, so only the bench scenarios show them, comparing every grant each cycle against a model of the in-flight instructions kept in issue order.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU  = 5;
    localparam int NUM_REG = 16;
    localparam int FU_W    = $clog2(NUM_FU);
    localparam int REG_W   = $clog2(NUM_REG);

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_ADD = 2'd3
    } fu_class_e;

    // Unit index to class: 0 integer, 1..2 multiply, 3 divide, 4 add.
    function automatic fu_class_e fu_class(input int idx);
        case (idx)
            0:       return CLS_INT;
            1, 2:    return CLS_MUL;
            3:       return CLS_DIV;
            default: return CLS_ADD;
        endcase
    endfunction

    typedef struct packed {
        logic             busy;
        logic             rd_done;   // operands taken from register file
        logic             ex_done;   // unit reported completion
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [FU_W-1:0]  qj;
        logic [FU_W-1:0]  qk;
        logic             rj;        // source ready and not yet read
        logic             rk;
    } fu_entry_t;

    typedef struct packed {
        logic            valid;
        logic [FU_W-1:0] fu;
    } reg_stat_t;

    typedef struct packed {
        fu_entry_t [NUM_FU-1:0]  fu;
        reg_stat_t [NUM_REG-1:0] rs;
    } sb_state_t;
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic [NUM_FU-1:0] busy_i,
    input  fu_class_e         cls_i,
    input  logic              valid_i,
    input  logic              waw_i,
    output logic              accept_o,
    output logic [FU_W-1:0]   fu_o
);
    logic found;

    always_comb begin
        found = 1'b0;
        fu_o  = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (!busy_i[i] && fu_class(i) == cls_i) begin
                found = 1'b1;
                fu_o  = FU_W'(i);
            end
        end
        accept_o = valid_i && found && !waw_i;
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  fu_entry_t [NUM_FU-1:0] ent_i,
    output logic      [NUM_FU-1:0] grant_o,
    output logic                   any_o,
    output logic      [FU_W-1:0]   fu_o
);
    logic [NUM_FU-1:0] elig;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_war
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int e = 0; e < NUM_FU; e++) begin
                if (e != u && ent_i[e].busy &&
                    ((ent_i[e].rj && ent_i[e].fj == ent_i[u].fi) ||
                     (ent_i[e].rk && ent_i[e].fk == ent_i[u].fi)))
                    blk = 1'b1;
            end
        end
        assign elig[u] = ent_i[u].busy && ent_i[u].rd_done && ent_i[u].ex_done && !blk;
    end

    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        fu_o    = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                any_o   = 1'b1;
                fu_o    = FU_W'(i);
            end
        end
    end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [1:0]          in_cls_i,
    input  logic [REG_W-1:0]    in_dst_i,
    input  logic [REG_W-1:0]    in_src1_i,
    input  logic [REG_W-1:0]    in_src2_i,
    output logic                iss_accept_o,
    output logic [FU_W-1:0]     iss_fu_o,
    output logic [NUM_FU-1:0]   rd_grant_o,
    input  logic [NUM_FU-1:0]   ex_done_i,
    output logic [NUM_FU-1:0]   wb_grant_o,
    output logic [REG_W-1:0]    wb_reg_o
);
    sb_state_t st_q, st_d;

    logic [NUM_FU-1:0] busy_vec;
    logic              wb_any;
    logic [FU_W-1:0]   wb_fu;

    always_comb begin
        for (int i = 0; i < NUM_FU; i++) busy_vec[i] = st_q.fu[i].busy;
    end

    sb_issue_sel u_iss (
        .busy_i   (busy_vec),
        .cls_i    (fu_class_e'(in_cls_i)),
        .valid_i  (in_valid_i),
        .waw_i    (st_q.rs[in_dst_i].valid),
        .accept_o (iss_accept_o),
        .fu_o     (iss_fu_o)
    );

    sb_wb_arb u_wb (
        .ent_i   (st_q.fu),
        .grant_o (wb_grant_o),
        .any_o   (wb_any),
        .fu_o    (wb_fu)
    );

    assign wb_reg_o = st_q.fu[wb_fu].fi;

    always_comb begin
        for (int i = 0; i < NUM_FU; i++)
            rd_grant_o[i] = st_q.fu[i].busy && !st_q.fu[i].rd_done &&
                            st_q.fu[i].rj && st_q.fu[i].rk;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FU; i++) begin
            if (ex_done_i[i] && st_q.fu[i].busy && st_q.fu[i].rd_done)
                st_d.fu[i].ex_done = 1'b1;
            if (rd_grant_o[i]) begin
                st_d.fu[i].rd_done = 1'b1;
                st_d.fu[i].rj      = 1'b0;
                st_d.fu[i].rk      = 1'b0;
            end
        end
        if (wb_any) begin
            st_d.fu[wb_fu] = '0;
            st_d.rs[st_q.fu[wb_fu].fi] = '0;
            for (int e = 0; e < NUM_FU; e++) begin
                if (st_q.fu[e].busy && !st_q.fu[e].rd_done) begin
                    if (!st_q.fu[e].rj && st_q.fu[e].qj == wb_fu) begin
                        st_d.fu[e].rj = 1'b1;
                        st_d.fu[e].qj = '0;
                    end
                    if (!st_q.fu[e].rk && st_q.fu[e].qk == wb_fu) begin
                        st_d.fu[e].rk = 1'b1;
                        st_d.fu[e].qk = '0;
                    end
                end
            end
        end
        if (iss_accept_o) begin
            st_d.fu[iss_fu_o].busy    = 1'b1;
            st_d.fu[iss_fu_o].rd_done = 1'b0;
            st_d.fu[iss_fu_o].ex_done = 1'b0;
            st_d.fu[iss_fu_o].fi      = in_dst_i;
            st_d.fu[iss_fu_o].fj      = in_src1_i;
            st_d.fu[iss_fu_o].fk      = in_src2_i;
            st_d.fu[iss_fu_o].qj      = st_q.rs[in_src1_i].valid ? st_q.rs[in_src1_i].fu : '0;
            st_d.fu[iss_fu_o].qk      = st_q.rs[in_src2_i].valid ? st_q.rs[in_src2_i].fu : '0;
            st_d.fu[iss_fu_o].rj      = !st_q.rs[in_src1_i].valid ||
                                        (wb_any && st_q.rs[in_src1_i].fu == wb_fu);
            st_d.fu[iss_fu_o].rk      = !st_q.rs[in_src2_i].valid ||
                                        (wb_any && st_q.rs[in_src2_i].fu == wb_fu);
            st_d.rs[in_dst_i].valid   = 1'b1;
            st_d.rs[in_dst_i].fu      = iss_fu_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: one write-back per cycle
    a_r9_wb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant_o));

    // R2: accepted instruction lands in an idle unit of its class
    a_r2_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept_o |-> (!st_q.fu[iss_fu_o].busy &&
                          fu_class(int'(iss_fu_o)) == fu_class_e'(in_cls_i)));

    // R3: after issue the destination is owned by the chosen unit
    a_r3_dst_owned: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept_o |=> (st_q.rs[$past(in_dst_i)].valid &&
                          st_q.rs[$past(in_dst_i)].fu == $past(iss_fu_o)));

    for (genvar i = 0; i < NUM_FU; i++) begin : g_chk
        // R7: write-back only after operand read and completion
        a_r7_wb_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant_o[i] |-> (st_q.fu[i].rd_done && st_q.fu[i].ex_done));
        // R6: one read grant per instruction
        a_r6_read_once: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant_o[i] |=> !rd_grant_o[i]);
        // R11: write-back frees the unit
        a_r11_unit_freed: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant_o[i] |=> !st_q.fu[i].busy);
    end
endmodule

// File: tb/sim_scoreboard_ctrl.sv
`timescale 1ns/1ps
module sim_scoreboard_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_cls = '0;
    logic [3:0] in_dst = '0, in_s1 = '0, in_s2 = '0;
    logic [4:0] ex_done = '0;
    logic       iss_accept;
    logic [2:0] iss_fu;
    logic [4:0] rd_grant, wb_grant;
    logic [3:0] wb_reg;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scoreboard_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_cls_i(in_cls), .in_dst_i(in_dst),
        .in_src1_i(in_s1), .in_src2_i(in_s2),
        .iss_accept_o(iss_accept), .iss_fu_o(iss_fu),
        .rd_grant_o(rd_grant), .ex_done_i(ex_done),
        .wb_grant_o(wb_grant), .wb_reg_o(wb_reg)
    );

    // Model of in-flight instructions, indexed by unit
    bit m_busy[5], m_rd[5], m_done[5];
    int m_dst[5], m_s1[5], m_s2[5], m_seq[5];
    int seq = 0;
    bit last_acc;
    bit rnd_mode = 0;
    logic [4:0] done_mask = '1;

    function automatic int cls_of(int u);
        if (u == 0) return 0;
        if (u <= 2) return 1;
        if (u == 3) return 2;
        return 3;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit older_writer(int i);
        for (int j = 0; j < 5; j++)
            if (m_busy[j] && m_seq[j] < m_seq[i] &&
                (m_dst[j] == m_s1[i] || m_dst[j] == m_s2[i])) return 1;
        return 0;
    endfunction

    function automatic bit war_block(int i);
        for (int j = 0; j < 5; j++)
            if (j != i && m_busy[j] && !m_rd[j] && m_seq[j] < m_seq[i] &&
                (m_s1[j] == m_dst[i] || m_s2[j] == m_dst[i])) return 1;
        return 0;
    endfunction

    // Sets ex_done from the model, then checks all outputs and advances one edge.
    task automatic cycle();
        bit found, waw, exp_acc;
        int exp_fu, exp_wbu;
        logic [4:0] exp_rd, exp_wb;
        for (int u = 0; u < 5; u++) begin
            bit real_done = m_busy[u] && m_rd[u] && !m_done[u] && done_mask[u];
            if (rnd_mode) ex_done[u] = (real_done && ($urandom % 3 == 0)) || ($urandom % 20 == 0);
            else          ex_done[u] = real_done;
        end
        #1;
        found = 0; exp_fu = 0;
        for (int u = 4; u >= 0; u--)
            if (!m_busy[u] && cls_of(u) == int'(in_cls)) begin found = 1; exp_fu = u; end
        waw = 0;
        for (int u = 0; u < 5; u++) if (m_busy[u] && m_dst[u] == int'(in_dst)) waw = 1;
        exp_acc = in_valid && found && !waw;
        chk(iss_accept == exp_acc, "R2 R3 R4 accept", iss_accept, exp_acc);
        if (exp_acc) chk(int'(iss_fu) == exp_fu, "R2 unit", iss_fu, exp_fu);
        for (int u = 0; u < 5; u++)
            exp_rd[u] = m_busy[u] && !m_rd[u] && !older_writer(u);
        chk(rd_grant == exp_rd, "R5 R6 read grant", rd_grant, exp_rd);
        exp_wb = '0; exp_wbu = -1;
        for (int u = 4; u >= 0; u--)
            if (m_busy[u] && m_done[u] && !war_block(u)) exp_wbu = u;
        if (exp_wbu >= 0) exp_wb[exp_wbu] = 1'b1;
        chk(wb_grant == exp_wb, "R7 R8 R9 R12 wb grant", wb_grant, exp_wb);
        if (exp_wbu >= 0) chk(int'(wb_reg) == m_dst[exp_wbu], "R10 wb reg", wb_reg, m_dst[exp_wbu]);
        // model update for the coming edge
        for (int u = 0; u < 5; u++) if (ex_done[u] && m_busy[u] && m_rd[u]) m_done[u] = 1;
        for (int u = 0; u < 5; u++) if (exp_rd[u]) m_rd[u] = 1;
        if (exp_wbu >= 0) m_busy[exp_wbu] = 0;
        if (exp_acc) begin
            m_busy[exp_fu] = 1; m_rd[exp_fu] = 0; m_done[exp_fu] = 0;
            m_dst[exp_fu] = in_dst; m_s1[exp_fu] = in_s1; m_s2[exp_fu] = in_s2;
            m_seq[exp_fu] = seq++;
        end
        last_acc = exp_acc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_instr(int c, int d, int a, int b);
        in_valid = 1; in_cls = 2'(c); in_dst = 4'(d); in_s1 = 4'(a); in_s2 = 4'(b);
        do cycle(); while (!last_acc);
        in_valid = 0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    function automatic bit model_empty();
        for (int u = 0; u < 5; u++) if (m_busy[u]) return 0;
        return 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(rd_grant == 5'd0, "R1 read idle", rd_grant, 0);
        chk(wb_grant == 5'd0, "R1 wb idle", wb_grant, 0);
        chk(iss_accept == 1'b0, "R1 no accept without valid", iss_accept, 0);
        @(negedge clk);
        // R1 R6: independent integer instruction issues and reads at once
        run_instr(0, 1, 2, 3);
        idle(4);
        // R2 R5: two multiplies, second depends on first; third stalls (structural)
        done_mask = 5'b00000;
        run_instr(1, 4, 0, 1);
        run_instr(1, 5, 4, 2);
        in_valid = 1; in_cls = 2'd1; in_dst = 4'd6; in_s1 = 4'd0; in_s2 = 4'd0;
        cycle(); cycle();                 // R4: held while no multiplier is idle
        done_mask = 5'b11111;
        do cycle(); while (!last_acc);    // R11: accepted once a multiplier frees
        in_valid = 0;
        idle(6);
        // R3: destination pending -> stall; R11: accepted right after write-back
        done_mask = 5'b00000;
        run_instr(3, 7, 0, 1);
        in_valid = 1; in_cls = 2'd0; in_dst = 4'd7; in_s1 = 4'd2; in_s2 = 4'd3;
        cycle(); cycle();
        done_mask = 5'b11111;
        do cycle(); while (!last_acc);
        in_valid = 0;
        idle(6);
        // R8: consumer waiting on slow producer blocks a later writer of its other source
        done_mask = 5'b00000;
        run_instr(1, 8, 0, 1);            // unit 1 writes r8
        run_instr(3, 10, 8, 3);           // unit 4 reads r8 and r3
        run_instr(0, 3, 1, 2);            // unit 0 writes r3
        done_mask = 5'b00001;
        idle(5);                          // unit 0 complete but held
        done_mask = 5'b11111;
        idle(8);
        // R9: two completions in the same cycle
        done_mask = 5'b00000;
        run_instr(0, 11, 0, 1);
        run_instr(2, 12, 0, 1);
        idle(3);
        done_mask = 5'b11111;
        idle(6);
        // R12: stray completion pulses on idle units
        rnd_mode = 1;
        idle(20);
        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            run_instr($urandom % 4, $urandom % 6, $urandom % 6, $urandom % 6);
            if ($urandom % 4 == 0) idle($urandom % 4);
        end
        rnd_mode = 0;
        idle(30);
        chk(model_empty(), "R11 all drained", 0, 1);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule